// File: doc/BRIEF.md
# Cartridge Bank-Swap Address Decoder

This block sits between a 16-bit-data host bus with a 24-bit byte address and three cartridge memories: an internal ROM, a 64 KB battery-backed SRAM and an external pass-through cartridge. For every bus strobe it reports which target is addressed, the ROM address to present, and, for writes, whether the SRAM is written and which byte lanes are enabled. Two 8-bit registers, a mode register and a kill register, are loaded from the bus at two alias locations.

Bit 4 of the mode register is the swap bit. When it is clear, the ROM occupies the bottom 2 MB of the space and the SRAM sits just above the 2 MB line. When it is set, the SRAM moves to the bottom 64 KB, the external cartridge appears just above the 2 MB line, and the ROM is reached higher up at an address offset. SRAM writes are accepted only in the half of the space that currently holds the SRAM. Whenever the swap bit changes, a one-cycle pulse is produced so that downstream caches can be flushed.

Top module: `cart_swap_decoder`

## Requirements
- R1: After a synchronous active-high reset, `ctrlReg` and `killReg` read 0x00 and `swapFlip` is low.
- R2: With the swap bit clear, a valid access to 0x000000–0x1FFFFF selects ROM with `romAddr` equal to the bus address, 0x200000–0x20FFFF selects SRAM, and any other address outside the register alias selects nothing.
- R3: With the swap bit set, 0x000000–0x00FFFF selects SRAM, 0x010000–0x1FFFFF selects nothing, 0x200000–0x20FFFF selects the external cartridge, 0x210000–0x3BBFFF selects ROM with `romAddr` equal to the bus address minus 0x100000, and addresses from 0x3BC000 up select nothing.
- R4: Any valid access to 0x3BFE00–0x3BFE03 selects the register target; a register-loading write at the low alias (R7) also selects it. `romAddr` is zero whenever ROM is not selected.
- R5: `sramWrEn` is high only for a valid write that is not a register write and whose address is below 0x200000 with the swap bit set, or in 0x200000–0x3BBFFF with the swap bit clear; such writes reach the SRAM through every 64 KB mirror of that half.
- R6: `sramAddr` is the low 16 bits of the bus address. A word write enables both lanes (`sramByteEn` = 2'b11) with `sramWdata` equal to the bus data; a byte write enables bit 1 (upper lane) for an even address or bit 0 (lower lane) for an odd one, with the byte from `busWdata[7:0]` on both lanes.
- R7: A byte write to 0x000181 loads `killReg` and to 0x000183 loads `ctrlReg`, from `busWdata[7:0]`; a word write to 0x000180 or 0x000182 acts the same as a byte write to the following odd address. Such writes never assert `sramWrEn`.
- R8: Byte writes to 0x3BFE01 and 0x3BFE03, and word writes to 0x3BFE00 and 0x3BFE02, load `killReg` and `ctrlReg` respectively in the same way.
- R9: Only bit 4 of `ctrlReg` changes the mapping; the other seven bits have no effect on selection.
- R10: `swapFlip` is high for exactly the one cycle in which the new `ctrlReg` value first appears, and only if bit 4 differs from its previous value.
- R11: `selKind` encodes the target as NONE=0, ROM=1, SRAM=2, EXT=3, REG=4, and exactly the matching one of `selRom`, `selSram`, `selExt`, `selReg` is high (none for NONE); an idle bus (`busValid` low) gives NONE.
- R12: Registers keep their values without a loading write: reads, byte writes to an even alias address (which are handled as ordinary memory writes) and writes elsewhere leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Single-cycle access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWord | input | 1 | 1 = 16-bit access, 0 = byte access |
| busAddr | input | 24 | Byte address |
| busWdata | input | 16 | Write data |
| selKind | output | 3 | Encoded target (R11) |
| selRom | output | 1 | Internal ROM selected |
| selSram | output | 1 | SRAM selected |
| selExt | output | 1 | External cartridge selected |
| selReg | output | 1 | Register alias selected |
| romAddr | output | 22 | Byte address into the internal ROM |
| sramAddr | output | 16 | Byte address into the SRAM |
| sramWrEn | output | 1 | SRAM write accepted |
| sramByteEn | output | 2 | Lane enables, bit 1 upper byte, bit 0 lower byte |
| sramWdata | output | 16 | SRAM write data per lane |
| ctrlReg | output | 8 | Mode register, bit 4 = swap |
| killReg | output | 8 | Kill register |
| swapFlip | output | 1 | One-cycle pulse when the swap bit changes |

## Verification
On every cycle the assertions check that an accepted SRAM write lies in the half that holds the SRAM and always carries at least one lane, that a register load never also writes the SRAM, that both registers hold still without a load, and that the flip pulse only accompanies a real change of the swap bit. Which target each address maps to in each swap state, the ROM offset, the exact lane and data steering, which alias addresses load which register, and the pulse lasting exactly one cycle can only be shown by the bench's directed scenarios and its randomized address sweep against a reference model.

// File: rtl/cart_swap_pkg.sv
package cart_swap_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_ROM  = 3'd1,
    SEL_SRAM = 3'd2,
    SEL_EXT  = 3'd3,
    SEL_REG  = 3'd4
  } selKind_e;

  // Strobes from the decode control to the register/lane datapath
  typedef struct packed {
    logic killLoad;
    logic ctrlLoad;
    logic sramWrite;
    logic laneHi;
    logic laneLo;
    logic wordAccess;
  } strobe_t;

endpackage

// File: rtl/cart_swap_ctrl.sv
module cart_swap_ctrl
  import cart_swap_pkg::*;
#(
  parameter int          ADDR_W       = 24,
  parameter logic [23:0] LOW_ALIAS    = 24'h000180,
  parameter logic [23:0] HIGH_ALIAS   = 24'h3BFE00,
  parameter logic [23:0] HI_BASE      = 24'h200000,
  parameter logic [23:0] SRAM_SPAN    = 24'h010000,
  parameter logic [23:0] REG_WIN_BASE = 24'h3BC000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busWord,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              swapOn,
  output strobe_t           strobes,
  output selKind_e          selKind
);

  localparam logic [ADDR_W-1:0] HI_END   = ADDR_W'(HI_BASE + SRAM_SPAN);
  localparam logic [ADDR_W-1:0] LOW_END  = ADDR_W'(SRAM_SPAN);
  localparam logic [ADDR_W-1:0] HI_START = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] REG_WIN  = ADDR_W'(REG_WIN_BASE);
  localparam logic [ADDR_W-3:0] LOW_TAG  = LOW_ALIAS[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] HIGH_TAG = HIGH_ALIAS[ADDR_W-1:2];

  logic aliasLowHit;
  logic aliasHighHit;
  logic regLaneOk;
  logic regWriteHit;
  logic upperHalf;
  logic inCartArea;
  logic windowOpen;
  logic sramWrite;

  always_comb begin
    aliasLowHit  = (busAddr[ADDR_W-1:2] == LOW_TAG);
    aliasHighHit = (busAddr[ADDR_W-1:2] == HIGH_TAG);
    // a word access must be even, a byte access must hit the odd byte
    regLaneOk    = busWord ? ~busAddr[0] : busAddr[0];
    regWriteHit  = busValid & busWrite & regLaneOk & (aliasLowHit | aliasHighHit);
    upperHalf    = (busAddr >= HI_START);
    inCartArea   = (busAddr < REG_WIN);
    windowOpen   = swapOn ? ~upperHalf : (upperHalf & inCartArea);
    sramWrite    = busValid & busWrite & windowOpen & ~regWriteHit;
  end

  always_comb begin
    strobes.killLoad   = regWriteHit & ~busAddr[1];
    strobes.ctrlLoad   = regWriteHit &  busAddr[1];
    strobes.sramWrite  = sramWrite;
    strobes.laneHi     = sramWrite & (busWord | ~busAddr[0]);
    strobes.laneLo     = sramWrite & (busWord |  busAddr[0]);
    strobes.wordAccess = busWord;
  end

  always_comb begin
    selKind = SEL_NONE;
    if (!busValid) begin
      selKind = SEL_NONE;
    end else if (aliasHighHit || regWriteHit) begin
      selKind = SEL_REG;
    end else if (!swapOn) begin
      if (!upperHalf)             selKind = SEL_ROM;
      else if (busAddr < HI_END)  selKind = SEL_SRAM;
      else                        selKind = SEL_NONE;
    end else begin
      if (busAddr < LOW_END)      selKind = SEL_SRAM;
      else if (!upperHalf)        selKind = SEL_NONE;
      else if (busAddr < HI_END)  selKind = SEL_EXT;
      else if (inCartArea)        selKind = SEL_ROM;
      else                        selKind = SEL_NONE;
    end
  end

  AST_SRAM_WINDOW: assert property (@(posedge clk) disable iff (rst)
    strobes.sramWrite |-> (busWrite && (swapOn ? (busAddr < HI_START)
                                               : (busAddr >= HI_START && busAddr < REG_WIN)))); // R5

  AST_LANE_PRESENT: assert property (@(posedge clk) disable iff (rst)
    strobes.sramWrite |-> (strobes.laneHi || strobes.laneLo)); // R6

  AST_REG_NOT_SRAM: assert property (@(posedge clk) disable iff (rst)
    (strobes.killLoad || strobes.ctrlLoad) |-> !strobes.sramWrite); // R7

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busValid |-> (selKind == SEL_NONE)); // R11

endmodule

// File: rtl/cart_swap_datapath.sv
module cart_swap_datapath
  import cart_swap_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          REG_W     = 8,
  parameter int          ROM_W     = 22,
  parameter int          SWAP_BIT  = 4,
  parameter logic [23:0] ROM_SHIFT = 24'h100000
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  selKind_e          selKind,
  input  logic              swapOn,
  input  logic [ROM_W-1:0]  romSrcAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [ROM_W-1:0]  romAddr,
  output logic              sramWrEn,
  output logic [1:0]        sramByteEn,
  output logic [DATA_W-1:0] sramWdata,
  output logic [REG_W-1:0]  ctrlReg,
  output logic [REG_W-1:0]  killReg,
  output logic              swapFlip
);

  localparam int LANE_W = DATA_W / 2;
  localparam logic [ROM_W-1:0] SHIFT_T = ROM_SHIFT[ROM_W-1:0];

  logic [1:0]       laneSel;
  logic [REG_W-1:0] regData;
  logic [ROM_W-1:0] romShifted;

  assign regData    = busWdata[REG_W-1:0];
  assign laneSel    = {strobes.laneHi, strobes.laneLo};
  assign romShifted = romSrcAddr - SHIFT_T;

  always_comb begin
    if (selKind == SEL_ROM) romAddr = swapOn ? romShifted : romSrcAddr;
    else                    romAddr = '0;
  end

  assign sramWrEn = strobes.sramWrite;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : gLane
      assign sramByteEn[g] = laneSel[g];
      assign sramWdata[g*LANE_W +: LANE_W] = strobes.wordAccess
                                             ? busWdata[g*LANE_W +: LANE_W]
                                             : busWdata[LANE_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg  <= '0;
      killReg  <= '0;
      swapFlip <= 1'b0;
    end else begin
      swapFlip <= strobes.ctrlLoad & (regData[SWAP_BIT] ^ ctrlReg[SWAP_BIT]);
      if (strobes.ctrlLoad) ctrlReg <= regData;
      if (strobes.killLoad) killReg <= regData;
    end
  end

  AST_FLIP_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    swapFlip |-> (ctrlReg[SWAP_BIT] != $past(ctrlReg[SWAP_BIT]))); // R10

  AST_FLIP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    swapFlip |=> !swapFlip || $past(strobes.ctrlLoad)); // R10

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobes.ctrlLoad)) |-> $stable(ctrlReg)); // R12

  AST_KILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobes.killLoad)) |-> $stable(killReg)); // R12

endmodule

// File: rtl/cart_swap_decoder.sv
module cart_swap_decoder
  import cart_swap_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int REG_W    = 8,
  parameter int ROM_W    = 22,
  parameter int SRAM_AW  = 16,
  parameter int SWAP_BIT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic               busWord,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [2:0]         selKind,
  output logic               selRom,
  output logic               selSram,
  output logic               selExt,
  output logic               selReg,
  output logic [ROM_W-1:0]   romAddr,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic               sramWrEn,
  output logic [1:0]         sramByteEn,
  output logic [DATA_W-1:0]  sramWdata,
  output logic [REG_W-1:0]   ctrlReg,
  output logic [REG_W-1:0]   killReg,
  output logic               swapFlip
);

  strobe_t  strobes;
  selKind_e kind;

  cart_swap_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .busValid (busValid),
    .busWrite (busWrite),
    .busWord  (busWord),
    .busAddr  (busAddr),
    .swapOn   (ctrlReg[SWAP_BIT]),
    .strobes  (strobes),
    .selKind  (kind)
  );

  cart_swap_datapath #(
    .DATA_W   (DATA_W),
    .REG_W    (REG_W),
    .ROM_W    (ROM_W),
    .SWAP_BIT (SWAP_BIT)
  ) uData (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .selKind    (kind),
    .swapOn     (ctrlReg[SWAP_BIT]),
    .romSrcAddr (busAddr[ROM_W-1:0]),
    .busWdata   (busWdata),
    .romAddr    (romAddr),
    .sramWrEn   (sramWrEn),
    .sramByteEn (sramByteEn),
    .sramWdata  (sramWdata),
    .ctrlReg    (ctrlReg),
    .killReg    (killReg),
    .swapFlip   (swapFlip)
  );

  assign sramAddr = busAddr[SRAM_AW-1:0];
  assign selKind  = kind;
  assign selRom   = (kind == SEL_ROM);
  assign selSram  = (kind == SEL_SRAM);
  assign selExt   = (kind == SEL_EXT);
  assign selReg   = (kind == SEL_REG);

endmodule

// File: tb/cart_swap_decoder_test.sv
`timescale 1ns/100ps
module cart_swap_decoder_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        busValid, busWrite, busWord;
  logic [23:0] busAddr;
  logic [15:0] busWdata;
  logic [2:0]  selKind;
  logic        selRom, selSram, selExt, selReg;
  logic [21:0] romAddr;
  logic [15:0] sramAddr;
  logic        sramWrEn;
  logic [1:0]  sramByteEn;
  logic [15:0] sramWdata;
  logic [7:0]  ctrlReg, killReg;
  logic        swapFlip;

  int testCount = 0;
  int failCount = 0;
  logic modelSwap = 1'b0;

  always #2.5 clk = ~clk;

  cart_swap_decoder uut (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busWord(busWord),
    .busAddr(busAddr), .busWdata(busWdata), .selKind(selKind), .selRom(selRom),
    .selSram(selSram), .selExt(selExt), .selReg(selReg), .romAddr(romAddr),
    .sramAddr(sramAddr), .sramWrEn(sramWrEn), .sramByteEn(sramByteEn),
    .sramWdata(sramWdata), .ctrlReg(ctrlReg), .killReg(killReg), .swapFlip(swapFlip)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference target: 0 none, 1 rom, 2 sram, 3 ext, 4 reg
  function automatic int refKind(input logic swp, input logic wr, input logic wd,
                                 input logic [23:0] a);
    logic laneOk;
    laneOk = wd ? ~a[0] : a[0];
    if (a >= 24'h3BFE00 && a <= 24'h3BFE03) return 4;
    if (wr && laneOk && a >= 24'h000180 && a <= 24'h000183) return 4;
    if (!swp) begin
      if (a < 24'h200000) return 1;
      if (a < 24'h210000) return 2;
      return 0;
    end
    if (a < 24'h010000) return 2;
    if (a < 24'h200000) return 0;
    if (a < 24'h210000) return 3;
    if (a < 24'h3BC000) return 1;
    return 0;
  endfunction

  task automatic idle();
    busValid = 1'b0; busWrite = 1'b0; busWord = 1'b0;
    busAddr = '0; busWdata = '0;
  endtask

  // present an access at a falling edge; combinational outputs settle 1 ns later
  task automatic present(input logic wr, input logic wd, input logic [23:0] a,
                         input logic [15:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busWord = wd; busAddr = a; busWdata = d;
    #1;
  endtask

  // finish the access: registers load at the rising edge, checked at the next falling edge
  task automatic finish();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic checkSel(input string tag, input int exp);
    logic [3:0] flags;
    check(tag, {29'd0, selKind}, exp);
    flags = {selReg, selExt, selSram, selRom};
    case (exp)
      1: check(tag, {28'd0, flags}, 32'h1);
      2: check(tag, {28'd0, flags}, 32'h2);
      3: check(tag, {28'd0, flags}, 32'h4);
      4: check(tag, {28'd0, flags}, 32'h8);
      default: check(tag, {28'd0, flags}, 32'h0);
    endcase
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    present(1'b1, 1'b0, 24'h3BFE03, {8'h00, v});
    finish();
    modelSwap = v[4];
  endtask

  task automatic testReset();
    check("R1 ctrl", {24'd0, ctrlReg}, 32'h0);
    check("R1 kill", {24'd0, killReg}, 32'h0);
    check("R1 flip", {31'd0, swapFlip}, 32'h0);
    #1; checkSel("R11 idle", 0);
  endtask

  task automatic testDecodeClear();
    present(1'b0, 1'b0, 24'h000000, '0); checkSel("R2 rom lo", 1);
    check("R2 romAddr lo", {10'd0, romAddr}, 32'h0);
    present(1'b0, 1'b1, 24'h1FFFFE, '0); checkSel("R2 rom top", 1);
    check("R2 romAddr top", {10'd0, romAddr}, 32'h1FFFFE);
    present(1'b0, 1'b0, 24'h200000, '0); checkSel("R2 sram lo", 2);
    check("R4 romAddr zero", {10'd0, romAddr}, 32'h0);
    present(1'b0, 1'b0, 24'h20FFFF, '0); checkSel("R2 sram top", 2);
    present(1'b0, 1'b0, 24'h210000, '0); checkSel("R2 none", 0);
    present(1'b0, 1'b0, 24'h3BFDFF, '0); checkSel("R2 none hi", 0);
    finish();
  endtask

  task automatic testDecodeSet();
    writeCtrl(8'h10);
    present(1'b0, 1'b0, 24'h000000, '0); checkSel("R3 sram lo", 2);
    present(1'b0, 1'b0, 24'h00FFFF, '0); checkSel("R3 sram top", 2);
    present(1'b0, 1'b0, 24'h010000, '0); checkSel("R3 gap", 0);
    present(1'b0, 1'b0, 24'h200000, '0); checkSel("R3 ext", 3);
    present(1'b0, 1'b0, 24'h20FFFF, '0); checkSel("R3 ext top", 3);
    present(1'b0, 1'b0, 24'h210000, '0); checkSel("R3 rom lo", 1);
    check("R3 romAddr lo", {10'd0, romAddr}, 32'h110000);
    present(1'b0, 1'b0, 24'h3BBFFF, '0); checkSel("R3 rom top", 1);
    check("R3 romAddr top", {10'd0, romAddr}, 32'h2BBFFF);
    present(1'b0, 1'b0, 24'h3BC000, '0); checkSel("R3 above", 0);
    finish();
    writeCtrl(8'h00);
  endtask

  task automatic testRegSelect();
    present(1'b0, 1'b0, 24'h3BFE00, '0); checkSel("R4 high read", 4);
    present(1'b0, 1'b0, 24'h000181, '0); checkSel("R4 low read is rom", 1);
    present(1'b1, 1'b0, 24'h000183, 16'h0000); checkSel("R4 low write", 4);
    finish();
  endtask

  task automatic testWriteWindow();
    present(1'b1, 1'b0, 24'h000400, 16'h0011);
    check("R5 clear low dropped", {31'd0, sramWrEn}, 32'h0);
    present(1'b1, 1'b0, 24'h200400, 16'h0011);
    check("R5 clear high ok", {31'd0, sramWrEn}, 32'h1);
    present(1'b1, 1'b1, 24'h3A1234, 16'h0011);
    check("R5 clear mirror", {31'd0, sramWrEn}, 32'h1);
    check("R6 mirror addr", {16'd0, sramAddr}, 32'h1234);
    present(1'b1, 1'b0, 24'h3BC001, 16'h0011);
    check("R5 reg window no sram", {31'd0, sramWrEn}, 32'h0);
    present(1'b0, 1'b0, 24'h200400, 16'h0011);
    check("R5 read no write", {31'd0, sramWrEn}, 32'h0);
    finish();
    writeCtrl(8'h10);
    present(1'b1, 1'b0, 24'h050007, 16'h0022);
    check("R5 set low mirror", {31'd0, sramWrEn}, 32'h1);
    present(1'b1, 1'b0, 24'h200400, 16'h0022);
    check("R5 set high dropped", {31'd0, sramWrEn}, 32'h0);
    finish();
    writeCtrl(8'h00);
  endtask

  task automatic testLanes();
    present(1'b1, 1'b1, 24'h20ABCE, 16'hBEEF);
    check("R6 word en", {30'd0, sramByteEn}, 32'h3);
    check("R6 word data", {16'd0, sramWdata}, 32'hBEEF);
    check("R6 addr", {16'd0, sramAddr}, 32'hABCE);
    present(1'b1, 1'b0, 24'h200010, 16'h995A);
    check("R6 even byte en", {30'd0, sramByteEn}, 32'h2);
    check("R6 byte data", {16'd0, sramWdata}, 32'h5A5A);
    present(1'b1, 1'b0, 24'h200011, 16'h33C3);
    check("R6 odd byte en", {30'd0, sramByteEn}, 32'h1);
    check("R6 odd data", {16'd0, sramWdata}, 32'hC3C3);
    finish();
  endtask

  task automatic testLowAlias();
    writeCtrl(8'h10);
    present(1'b1, 1'b0, 24'h000181, 16'h00A5);
    check("R7 byte kill no sram", {31'd0, sramWrEn}, 32'h0);
    finish();
    check("R7 byte kill", {24'd0, killReg}, 32'hA5);
    present(1'b1, 1'b1, 24'h000180, 16'h773C);
    finish();
    check("R7 word kill", {24'd0, killReg}, 32'h3C);
    present(1'b1, 1'b1, 24'h000182, 16'h4411);
    check("R7 word ctrl no sram", {31'd0, sramWrEn}, 32'h0);
    finish();
    check("R7 word ctrl", {24'd0, ctrlReg}, 32'h11);
    present(1'b1, 1'b0, 24'h000180, 16'h00EE);
    check("R12 even byte to sram", {31'd0, sramWrEn}, 32'h1);
    check("R12 even byte lane", {30'd0, sramByteEn}, 32'h2);
    finish();
    check("R12 even byte kill kept", {24'd0, killReg}, 32'h3C);
    present(1'b1, 1'b0, 24'h000183, 16'h0000);
    finish();
    modelSwap = 1'b0;
    check("R7 byte ctrl", {24'd0, ctrlReg}, 32'h00);
  endtask

  task automatic testHighAlias();
    present(1'b1, 1'b0, 24'h3BFE01, 16'h0066);
    finish();
    check("R8 byte kill", {24'd0, killReg}, 32'h66);
    present(1'b1, 1'b1, 24'h3BFE02, 16'hAA0C);
    finish();
    check("R8 word ctrl", {24'd0, ctrlReg}, 32'h0C);
    present(1'b1, 1'b1, 24'h3BFE00, 16'h1277);
    finish();
    check("R8 word kill", {24'd0, killReg}, 32'h77);
    present(1'b0, 1'b0, 24'h3BFE01, 16'h0000);
    finish();
    check("R12 read kill kept", {24'd0, killReg}, 32'h77);
    present(1'b1, 1'b0, 24'h200001, 16'h0099);
    finish();
    check("R12 mem write ctrl kept", {24'd0, ctrlReg}, 32'h0C);
    writeCtrl(8'h00);
  endtask

  task automatic testSwapBitOnly();
    writeCtrl(8'hEF);
    present(1'b0, 1'b0, 24'h000100, '0); checkSel("R9 other bits rom", 1);
    present(1'b0, 1'b0, 24'h200000, '0); checkSel("R9 other bits sram", 2);
    finish();
    writeCtrl(8'h10);
    present(1'b0, 1'b0, 24'h000100, '0); checkSel("R9 swap bit", 2);
    finish();
    writeCtrl(8'h00);
  endtask

  task automatic testFlipPulse();
    present(1'b1, 1'b0, 24'h3BFE03, 16'h0010);
    @(negedge clk); idle(); #1;
    check("R10 pulse on set", {31'd0, swapFlip}, 32'h1);
    @(negedge clk); #1;
    check("R10 pulse one cycle", {31'd0, swapFlip}, 32'h0);
    present(1'b1, 1'b0, 24'h3BFE03, 16'h0013);
    finish();
    check("R10 no pulse same bit", {31'd0, swapFlip}, 32'h0);
    present(1'b1, 1'b1, 24'h000182, 16'h0000);
    finish();
    check("R10 pulse on clear", {31'd0, swapFlip}, 32'h1);
    modelSwap = 1'b0;
    @(negedge clk); #1;
    check("R10 pulse gone", {31'd0, swapFlip}, 32'h0);
  endtask

  task automatic testRandom();
    for (int pass = 0; pass < 2; pass++) begin
      writeCtrl(pass == 0 ? 8'h00 : 8'h10);
      for (int i = 0; i < 300; i++) begin
        logic [23:0] a;
        logic wd;
        a  = 24'($urandom_range(0, 24'h3FFFFF));
        wd = 1'($urandom_range(0, 1));
        if (wd) a[0] = 1'b0;
        present(1'b0, wd, a, '0);
        checkSel("R11 random", refKind(modelSwap, 1'b0, wd, a));
      end
      finish();
    end
    writeCtrl(8'h00);
  endtask

  initial begin
    #(200000 * 5);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    testReset();
    testDecodeClear();
    testDecodeSet();
    testRegSelect();
    testWriteWindow();
    testLanes();
    testLowAlias();
    testHighAlias();
    testSwapBitOnly();
    testFlipPulse();
    testRandom();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule